// File: doc/BRIEF.md
# Rise Time and Timestamp Digitizer

This block sits in each readout channel. It turns the rise time of a detector pulse into a digital code by counting system clock cycles. Two comparator outputs drive it. An early trigger comparator starts the count. A later threshold comparator stops it, and its edge also captures a timestamp from a free-running counter. The readout uses the rise-time code to correct for the amplitude loss that depends on how deep in the sensor the charge was created. The timestamp tags the event in time.

Both comparator inputs are asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector. A 2-bit select sets the resolution of each code by dividing the count rate by 1, 2, 4 or 8. The rise-time code saturates instead of wrapping. If the stop edge never comes, a timeout ends the measurement. When a measurement finishes, a one-cycle strobe is raised. The codes then hold until the next accepted start.

Top module: `rise_stamp_digitizer`

## Requirements
- R1: While `rst` is high, and after it is released, `rise_code`, `stamp_code` and `done` are all zero until a measurement completes.
- R2: The comparator inputs are synchronized by two flops and then edge-detected. If `stop_cmp` is first sampled high at clock edge b during a measurement, `done` is high after edge b+2 and stays high until edge b+3.
- R3: Let the start input first be sampled high at edge a and the stop input at edge a+n, with n >= 1. Then `rise_code` = min(floor(n / 2^rt_sel), 127). The encoding of `rt_sel` is 0 for divide by 1, 1 for divide by 2, 2 for divide by 4 and 3 for divide by 8.
- R4: The 7-bit rise-time code saturates at 127 and never wraps to a small value.
- R5: Suppose no stop edge is accepted within TIMEOUT_CYC = 1024 clock cycles after the start is accepted. The start is accepted at edge a+2 when the input is first sampled at edge a. Then `done` pulses after edge a+1026, `rise_code` becomes 127 and `stamp_code` is 0.
- R6: `done` is high for exactly one clock cycle per measurement.
- R7: On an accepted stop, `stamp_code` = floor(C / 2^ts_sel) mod 4096, where `ts_sel` uses the same encoding as `rt_sel`. C is the number of clock edges since reset was released, modulo 32768, counted up to but not including the capture edge.
- R8: At the edge where a start is accepted, both codes clear to zero. Both then hold their values until that measurement completes, and they hold the completed values until the next accepted start.
- R9: A stop edge while no measurement is running is ignored: no `done` pulse, and both codes are unchanged.
- R10: A start edge while a measurement is running is ignored: the rise-time code still counts from the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (32 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start_cmp | input | 1 | Early trigger comparator output, asynchronous |
| stop_cmp | input | 1 | Threshold comparator output, asynchronous |
| rt_sel | input | 2 | Rise-time resolution select (divide by 2^rt_sel) |
| ts_sel | input | 2 | Timestamp resolution select (divide by 2^ts_sel) |
| rise_code | output | 7 | Latched rise-time code |
| stamp_code | output | 12 | Latched timestamp code |
| done | output | 1 | One-cycle measurement-complete strobe |

## Verification
Some properties are checked by assertions on every cycle:
- The strobe lasts a single cycle.
- A strobe is only ever preceded by a running measurement.
- Neither code changes except at a strobe or by clearing to zero.
- The running count, once it reaches all ones, stays there.

The exact values are shown only by the bench's scenarios. These cover:
- the code as a function of the start-to-stop interval for every divide setting;
- the three-edge latency from the stop input;
- the timeout edge;
- the captured timestamp under each timestamp resolution;
- the rejection of stray stop and repeated start edges.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
    localparam int RT_W   = 7;
    localparam int TS_W   = 12;
    localparam int SEL_W  = 2;
    localparam int PRE_W  = (1 << SEL_W) - 1;
    localparam int FREE_W = TS_W + PRE_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEAS = 1'b1
    } meas_state_e;

    typedef struct packed {
        logic [RT_W-1:0] rise;
        logic [TS_W-1:0] stamp;
    } meas_codes_t;

    function automatic logic [RT_W-1:0] sat_inc(input logic [RT_W-1:0] v, input logic en);
        return (en && (v != '1)) ? RT_W'(v + 1'b1) : v;
    endfunction
endpackage

// File: rtl/rsd_edge_sync.sv
module rsd_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise_pulse
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [2:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[1:0], async_in[g]};
        end
        assign rise_pulse[g] = sh_q[1] & ~sh_q[2];
    end
endmodule

// File: rtl/rsd_prescale.sv
module rsd_prescale
    import rsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q, cnt_nxt, mask;

    always_comb begin
        cnt_nxt = cnt_q + 1'b1;
        mask    = ~({PRE_W{1'b1}} << sel);
        tick    = run && ((cnt_nxt & mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/rsd_stamp_counter.sv
module rsd_stamp_counter
    import rsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic [TS_W-1:0]  stamp_now
);
    logic [FREE_W-1:0] free_q;

    always_ff @(posedge clk) begin
        if (rst) free_q <= '0;
        else     free_q <= free_q + 1'b1;
    end

    assign stamp_now = TS_W'(free_q >> sel);
endmodule

// File: rtl/rsd_rise_ctr.sv
module rsd_rise_ctr
    import rsd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024,
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_evt,
    input  logic            stop_evt,
    input  logic            tick,
    input  logic [TS_W-1:0] stamp_now,
    output logic            busy,
    output logic [RT_W-1:0] acc,
    output meas_codes_t     codes,
    output logic            done
);
    meas_state_e     state_q;
    logic [TO_W-1:0] elapsed_q, elapsed_nxt;
    logic [RT_W-1:0] acc_q, acc_nxt;
    logic            timeout_hit;

    always_comb begin
        elapsed_nxt = elapsed_q + 1'b1;
        acc_nxt     = sat_inc(acc_q, tick);
        timeout_hit = (elapsed_nxt == TO_W'(TIMEOUT_CYC));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            elapsed_q <= '0;
            acc_q     <= '0;
            codes     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_evt) begin
                        state_q   <= ST_MEAS;
                        elapsed_q <= '0;
                        acc_q     <= '0;
                        codes     <= '0;
                    end
                end
                ST_MEAS: begin
                    elapsed_q <= elapsed_nxt;
                    acc_q     <= acc_nxt;
                    if (stop_evt) begin
                        codes.rise  <= acc_nxt;
                        codes.stamp <= stamp_now;
                        done        <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else if (timeout_hit) begin
                        codes.rise  <= '1;
                        done        <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_MEAS);
    assign acc  = acc_q;
endmodule

// File: rtl/rise_stamp_digitizer.sv
module rise_stamp_digitizer
    import rsd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_cmp,
    input  logic             stop_cmp,
    input  logic [SEL_W-1:0] rt_sel,
    input  logic [SEL_W-1:0] ts_sel,
    output logic [RT_W-1:0]  rise_code,
    output logic [TS_W-1:0]  stamp_code,
    output logic             done
);
    logic [1:0]      edge_evt;
    logic            busy, tick;
    logic [RT_W-1:0] acc;
    logic [TS_W-1:0] stamp_now;
    meas_codes_t     codes;

    rsd_edge_sync #(.N(2)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   ({stop_cmp, start_cmp}),
        .rise_pulse (edge_evt)
    );

    rsd_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .sel  (rt_sel),
        .tick (tick)
    );

    rsd_stamp_counter u_stamp (
        .clk       (clk),
        .rst       (rst),
        .sel       (ts_sel),
        .stamp_now (stamp_now)
    );

    rsd_rise_ctr #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .start_evt (edge_evt[0]),
        .stop_evt  (edge_evt[1]),
        .tick      (tick),
        .stamp_now (stamp_now),
        .busy      (busy),
        .acc       (acc),
        .codes     (codes),
        .done      (done)
    );

    assign rise_code  = codes.rise;
    assign stamp_code = codes.stamp;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker
    import rsd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic [RT_W-1:0] acc,
    input logic [RT_W-1:0] rise_code,
    input logic [TS_W-1:0] stamp_code
);
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_needs_meas_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_rise_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rise_code) |-> (done || rise_code == '0));

    p_stamp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(stamp_code) |-> (done || stamp_code == '0));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && acc == '1) |=> (acc == '1));
endmodule

bind rise_stamp_digitizer rsd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .acc        (acc),
    .rise_code  (rise_code),
    .stamp_code (stamp_code)
);

// File: tb/rise_stamp_digitizer_bench.sv
`timescale 1ns/1ps
module rise_stamp_digitizer_bench;
    localparam int CLK_PERIOD = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_cmp = 1'b0, stop_cmp = 1'b0;
    logic [1:0] rt_sel = '0, ts_sel = '0;
    logic [6:0] rise_code;
    logic [11:0] stamp_code;
    logic       done;

    int vectors = 0, miscompares = 0;
    int bc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) bc <= 0;
        else     bc <= bc + 1;
    end

    rise_stamp_digitizer u_rise_stamp_digitizer (
        .clk(clk), .rst(rst), .start_cmp(start_cmp), .stop_cmp(stop_cmp),
        .rt_sel(rt_sel), .ts_sel(ts_sel), .rise_code(rise_code),
        .stamp_code(stamp_code), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic cleanup();
        @(negedge clk);
        start_cmp = 0; stop_cmp = 0;
        repeat (5) @(negedge clk);
    endtask

    function automatic int exp_stamp(input int c, input int sel);
        return ((c % 32768) >> sel) & 4095;
    endfunction

    task automatic measure(input int n, input int rsel, input int tsel);
        int er, es;
        @(negedge clk);
        rt_sel = rsel[1:0]; ts_sel = tsel[1:0];
        start_cmp = 1;
        if (n >= 5) begin
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(rise_code == 0 && done == 0, "R8 clear on start", rise_code, 0);
            repeat (n - 3) @(posedge clk);
        end else begin
            repeat (n) @(posedge clk);
        end
        @(negedge clk);
        stop_cmp = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        er = (n >> rsel) > 127 ? 127 : (n >> rsel);
        es = exp_stamp(bc - 1, tsel);
        check(done == 1, "R2 done latency", done, 1);
        check(rise_code == er, (er == 127) ? "R4 saturate" : "R3 rise code", rise_code, er);
        check(stamp_code == es, "R7 timestamp", stamp_code, es);
        @(negedge clk);
        check(done == 0, "R6 single strobe", done, 0);
        check(rise_code == er, "R8 hold rise", rise_code, er);
        check(stamp_code == es, "R8 hold stamp", stamp_code, es);
        cleanup();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int hr, hs;
        repeat (4) @(negedge clk);
        check(rise_code == 0 && stamp_code == 0 && done == 0, "R1 in reset", rise_code, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        check(rise_code == 0 && stamp_code == 0 && done == 0, "R1 after reset", stamp_code, 0);

        // R3 / R7 sweep over every divide setting and a range of intervals
        for (int rs = 0; rs < 4; rs++)
            for (int n = 1; n <= 140; n++)
                measure(n, rs, n % 4);

        // R4 saturation
        measure(200, 0, 1);
        measure(300, 1, 2);

        // R5 timeout with no stop edge
        for (int rs = 0; rs < 4; rs++) begin
            @(negedge clk);
            rt_sel = rs[1:0];
            start_cmp = 1;
            repeat (1026) @(posedge clk);
            @(negedge clk);
            check(done == 0, "R5 no early timeout", done, 0);
            @(posedge clk);
            @(negedge clk);
            check(done == 1, "R5 timeout strobe", done, 1);
            check(rise_code == 127, "R5 timeout code", rise_code, 127);
            check(stamp_code == 0, "R5 timeout stamp", stamp_code, 0);
            @(negedge clk);
            check(done == 0, "R6 timeout single strobe", done, 0);
            cleanup();
        end

        // R9 stray stop in idle
        measure(37, 2, 3);
        hr = rise_code; hs = stamp_code;
        @(negedge clk);
        stop_cmp = 1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(done == 0, "R9 stray stop no strobe", done, 0);
        end
        check(rise_code == hr, "R9 rise unchanged", rise_code, hr);
        check(stamp_code == hs, "R9 stamp unchanged", stamp_code, hs);
        cleanup();

        // R10 second start edge during a measurement
        for (int rs = 0; rs < 4; rs++) begin
            @(negedge clk);
            rt_sel = rs[1:0];
            start_cmp = 1;
            repeat (10) @(posedge clk);
            @(negedge clk); start_cmp = 0;
            repeat (10) @(posedge clk);
            @(negedge clk); start_cmp = 1;
            repeat (20) @(posedge clk);
            @(negedge clk); stop_cmp = 1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(done == 1, "R10 strobe", done, 1);
            check(rise_code == (40 >> rs), "R10 restart ignored", rise_code, 40 >> rs);
            cleanup();
        end

        finish_run();
    end
endmodule